// File: doc/BRIEF.md
# Signed Two's Complement Array Multiplier

This block multiplies two N-bit two's complement integers and returns their full 2N-bit two's complement product. It has no clock. The product settles after a fixed depth of logic. The block works on integers only. Tracking the binary point of fixed-point operands is left to the caller, who gets an exact result from which to take the slice the format needs.

The signs are handled inside the partial-product matrix, not by sign extension. Some terms of the matrix are inverted:

- every term that pairs the top bit of one operand with a lower bit of the other;
- the corner term pairing both top bits is not inverted.

Two constant ones are added, one in column N and one in column 2N-1. The matrix becomes N+1 rows of width 2N. A chain of full-adder stages reduces these rows in carry-save form to two rows. A ripple adder then merges the two rows into the product. Any carry out of the top column is dropped.

Top module: `bw_signed_mult`

## Requirements
- R1: For every pair of N-bit inputs, `prod` equals the two's complement product `a*x`, taken as a 2N-bit value.
- R2: `prod` is 2N bits wide and its top bit has weight -2^(2N-1). A nonzero positive operand times a negative operand gives `prod[2N-1]` = 1.
- R3: The most negative value times itself gives +2^(2N-2). This is the only input pair for which the two top bits of `prod` read 01.
- R4: If either operand is zero, `prod` is all zeros. This holds even though the complemented terms and the constant ones in the matrix are nonzero.
- R5: The most negative value times the most positive value gives -(2^(N-1))·(2^(N-1)-1).
- R6: -1 times -1 gives +1, and -1 times +1 gives all ones, so the carry out of column 2N-1 is discarded.
- R7: The result does not depend on operand order: `prod(a,x)` equals `prod(x,a)`.
- R8: The carry-save stages keep the total unchanged: the two reduced rows add, modulo 2^(2N), to the sum of all matrix rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Multiplicand, two's complement |
| x | input | N | Multiplier, two's complement |
| prod | output | 2N | Product, two's complement |

## Verification
The hardest case to reach is the one where the inverted sign terms and both constant ones must cancel exactly into the top column. This happens when both operands are at the most negative value, and also when one operand is zero while the matrix still holds its 2N fixed ones. The bench sweeps every one of the 1024 input pairs for N = 5, so these cases are covered. Named checks then pin the most-negative, all-ones and zero operands, along with the operand-swap property.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Sign-extend the low w bits of v to a longint.
  function automatic longint sext(input longint v, input int w);
    longint m;
    m = longint'(1) <<< w;
    v = v & (m - 1);
    if (((v >>> (w - 1)) & 1) != 0) return v - m;
    return v;
  endfunction

  // Reference integer product of two w-bit two's complement words.
  function automatic longint ref_mul(input longint av, input longint xv, input int w);
    return sext(av, w) * sext(xv, w);
  endfunction

  // One matrix term for operand bit i and multiplier bit j.
  // Sign row and sign column terms are inverted; the corner term is not.
  function automatic logic bw_term(input int i, input int j, input int n,
                                   input logic ai, input logic xj);
    logic top_i, top_j;
    top_i = (i == n - 1);
    top_j = (j == n - 1);
    if (top_i ^ top_j) return ~(ai & xj);
    return ai & xj;
  endfunction

endpackage

// File: rtl/bwm_ppgen.sv
module bwm_ppgen #(
  parameter int N = 5
) (
  input  logic [N-1:0]          a,
  input  logic [N-1:0]          x,
  output logic [N:0][2*N-1:0]   rows
);
  localparam int W = 2 * N;

  always_comb begin
    rows = '0;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        rows[j][i+j] = bwm_pkg::bw_term(i, j, N, a[i], x[j]);
      end
    end
    // constant ones in column N and column 2N-1
    rows[N][N]   = 1'b1;
    rows[N][W-1] = 1'b1;

    // R4: with a zero multiplicand only the 2N-2 inverted terms and the two constants remain
    if (!$isunknown({a, x}) && a == '0) begin
      a_r4_zero_matrix_ones: assert ($countones(rows) == W)
        else $error("R4 matrix ones %0d", $countones(rows));
    end
  end
endmodule

// File: rtl/bwm_csa_chain.sv
module bwm_csa_chain #(
  parameter int N = 5
) (
  input  logic [N:0][2*N-1:0] rows,
  output logic [2*N-1:0]      sum_row,
  output logic [2*N-1:0]      carry_row
);
  localparam int W = 2 * N;
  localparam int R = N + 1;
  localparam int STAGES = R - 2;

  logic [STAGES:0][W-1:0] st_s;
  logic [STAGES:0][W-1:0] st_c;

  assign st_s[0] = rows[0];
  assign st_c[0] = rows[1];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] maj;
    assign st_s[k+1] = st_s[k] ^ st_c[k] ^ rows[k+2];
    assign maj       = (st_s[k] & st_c[k]) | (st_s[k] & rows[k+2]) | (st_c[k] & rows[k+2]);
    assign st_c[k+1] = {maj[W-2:0], 1'b0};
  end

  assign sum_row   = st_s[STAGES];
  assign carry_row = st_c[STAGES];

  logic [W-1:0] row_total;
  always_comb begin
    row_total = '0;
    for (int r = 0; r < R; r++) row_total = row_total + rows[r];
    if (!$isunknown(rows)) begin
      // R8: reduction preserves the sum modulo 2^W
      a_r8_csa_keeps_total: assert (W'(sum_row + carry_row) == row_total)
        else $error("R8 reduced %0h total %0h", W'(sum_row + carry_row), row_total);
    end
  end
endmodule

// File: rtl/bwm_cpa.sv
module bwm_cpa #(
  parameter int W = 10
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum
);
  logic [W-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign sum[b] = op_a[b] ^ op_b[b] ^ cy[b];
    if (b < W - 1) begin : g_carry
      assign cy[b+1] = (op_a[b] & op_b[b]) | (op_a[b] & cy[b]) | (op_b[b] & cy[b]);
    end
  end
endmodule

// File: rtl/bw_signed_mult.sv
module bw_signed_mult #(
  parameter int N = 5
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   x,
  output logic [2*N-1:0] prod
);
  localparam int W = 2 * N;
  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

  logic [N:0][W-1:0] pp_rows;
  logic [W-1:0]      red_sum;
  logic [W-1:0]      red_carry;

  bwm_ppgen #(.N(N)) u_pp (
    .a(a), .x(x), .rows(pp_rows)
  );

  bwm_csa_chain #(.N(N)) u_csa (
    .rows(pp_rows), .sum_row(red_sum), .carry_row(red_carry)
  );

  bwm_cpa #(.W(W)) u_cpa (
    .op_a(red_sum), .op_b(red_carry), .sum(prod)
  );

  initial begin
    a_r1_width_ok: assert (N >= 2 && N <= 31) else $error("R1 N out of range");
  end

  always_comb begin
    if (!$isunknown({a, x})) begin
      a_r1_exact_product: assert (prod == W'(bwm_pkg::ref_mul(longint'(a), longint'(x), N)))
        else $error("R1 prod %0h", prod);
      if (a != '0 && x != '0) begin
        a_r2_sign_of_product: assert (prod[W-1] == (a[N-1] ^ x[N-1]))
          else $error("R2 sign bit %0b", prod[W-1]);
      end
      if (a == MOST_NEG && x == MOST_NEG) begin
        a_r3_most_negative_square: assert (prod[W-1:W-2] == 2'b01)
          else $error("R3 top bits %0b", prod[W-1:W-2]);
      end
      if (a == '0 || x == '0) begin
        a_r4_zero_operand: assert (prod == '0) else $error("R4 prod %0h", prod);
      end
    end
  end
endmodule

// File: tb/tb_bw_signed_mult.sv
module tb_bw_signed_mult;
  localparam int N = 5;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] a, x;
  logic [W-1:0] prod;

  bw_signed_mult #(.N(N)) dut (.a(a), .x(x), .prod(prod));

  int n_checks = 0;
  int n_fail   = 0;

  function automatic logic [W-1:0] expect_prod(input logic [N-1:0] av, input logic [N-1:0] xv);
    int ea, ex;
    ea = int'(av);
    ex = int'(xv);
    if (av[N-1]) ea = ea - (1 << N);
    if (xv[N-1]) ex = ex - (1 << N);
    return W'(ea * ex);
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0d x=%0d got=%0h exp=%0h", req, a, x, got, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] av, input logic [N-1:0] xv);
    @(posedge clk);
    a = av;
    x = xv;
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [W-1:0] first;
    a = '0;
    x = '0;
    @(negedge clk);
    check("R4 idle zero", prod, '0);

    // R1: exhaustive sweep
    for (int i = 0; i < (1 << N); i++) begin
      for (int j = 0; j < (1 << N); j++) begin
        apply(N'(i), N'(j));
        check("R1 exhaustive", prod, expect_prod(N'(i), N'(j)));
      end
    end

    // R2: mixed signs
    apply(5'd3, 5'b11110);
    check("R2 top bit", {9'd0, prod[W-1]}, 10'd1);
    check("R2 value", prod, 10'(-6));

    // R3: most negative squared
    apply(5'b10000, 5'b10000);
    check("R3 value", prod, 10'd256);
    check("R3 top two bits", {8'd0, prod[W-1:W-2]}, 10'd1);

    // R4: zero operand on each side
    apply(5'b10000, 5'd0);
    check("R4 x zero", prod, '0);
    apply(5'd0, 5'b11111);
    check("R4 a zero", prod, '0);

    // R5: most negative times most positive
    apply(5'b10000, 5'b01111);
    check("R5 value", prod, 10'(-240));

    // R6: all ones operands
    apply(5'b11111, 5'b11111);
    check("R6 minus one squared", prod, 10'd1);
    apply(5'b11111, 5'd1);
    check("R6 minus one times one", prod, 10'h3FF);

    // R7: operand order
    for (int i = 0; i < (1 << N); i += 3) begin
      for (int j = 0; j < (1 << N); j += 5) begin
        apply(N'(i), N'(j));
        first = prod;
        apply(N'(j), N'(i));
        check("R7 swap", prod, first);
      end
    end

    // R8: carry-save totals reach the output only through the final adder
    apply(5'b10101, 5'b01011);
    check("R8 reduced sum", prod, expect_prod(5'b10101, 5'b01011));

    finish_up();
  end
endmodule